// File: doc/BRIEF.md
# Fast-Page EDO DRAM Controller

This block sits between a simple word-request port and one 16-bit-wide asynchronous DRAM with extended-data-out timing. Each host request carries a word address, a write flag, two byte enables and write data. The controller splits the address into a row part and a column part and drives the multiplexed address bus together with the row strobe, one column strobe per byte lane, write enable and output enable.

After a row has been opened, it stays open. A later request to the same row needs only a column strobe cycle. A request to a different row, a refresh request, or the row-open time approaching its limit causes the row to be closed and precharged. Refresh uses the column-before-row scheme: both column strobes fall first and the row strobe follows. Read data is captured while the column strobe is still low and is returned with a one-cycle valid pulse. Every timing minimum is a parameter counted in clock cycles.

Top module: `edo_dram_ctrl`

## Requirements
- R1: While reset is held, the row strobe, both column strobes, write enable and output enable are high (inactive), the data drive enable is low and `rsp_valid` is low. Once reset has been released and no refresh is pending, `req_ready` is high.
- R2: Address bit split: bits 19:10 form the row and bits 9:0 form the column. When no row is open, a request first presents the row on `dram_addr` for one cycle with the row strobe high. The row strobe then falls, and the row stays on the bus for `T_RCD` cycles before the column is presented.
- R3: When a request targets the open row, it is served with a column strobe cycle only, and the row strobe does not fall again. A read hit returns `rsp_valid` `T_CAS+1` cycles after the accepting edge. A read that opens a row returns it `T_RCD+T_CAS+2` cycles after acceptance.
- R4: A request to a different row closes the open row. The row strobe is low for at least `T_RAS_MIN` cycles each time, and high for at least `T_RP` cycles before it falls again.
- R5: `dram_cas_n[0]` strobes data bits 7:0 and `dram_cas_n[1]` strobes bits 15:8. In an access, a lane's column strobe falls only when that lane's byte-enable bit (`req_be[0]` lower, `req_be[1]` upper) is set. With both bits clear, no strobe falls and the memory is left unchanged.
- R6: A write is an early write. Write enable is already low one cycle before the column strobe falls, the data bus is driven, output enable stays high, and no `rsp_valid` pulse is produced.
- R7: On a read, `rsp_valid` is a single-cycle pulse. `rsp_rdata` holds the data sampled on the last edge of the column-strobe-low window, with each byte lane whose enable is clear forced to zero.
- R8: The column strobe stays low for at least `T_CAS` cycles. Between page cycles it stays high for at least `T_CP` cycles.
- R9: A pending `ref_req` blocks acceptance of requests and closes any open row. Both column strobes are then held low for at least `T_CSR` cycles before the row strobe falls. A refresh holds the row strobe low for `T_RAS_MIN` cycles and ends with a one-cycle `ref_ack`. Stored data survives the refresh.
- R10: An idle open row is closed on its own before the row strobe has been low for `T_RASP_MAX` cycles. The next access to that row then reopens it with a new row strobe fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_addr | input | 20 | Word address, row in bits 19:10 |
| req_we | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte enables, bit 0 = lower lane |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 16 | Read data |
| ref_req | input | 1 | Refresh request, held until acknowledged |
| ref_ack | output | 1 | Refresh completed pulse |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 2 | Column strobes per lane, bit 0 lower |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_dq_out | output | 16 | Data toward the memory |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_out` |
| dram_dq_in | input | 16 | Data from the memory |

## Verification
A read that hits the open row must produce `rsp_valid` exactly `T_CAS+1` edges after the accepting edge. A read that opens a row must produce it after `T_RCD+T_CAS+2` edges. The bench counts falling clock edges from the handshake and compares that count with these two figures. It samples every output half a cycle after the edge that updates it, and a small memory model reacts to the strobes on the falling edge, so the data it returns is stable before the controller samples it. Row-open events and strobe run lengths are counted on the same falling edges. This lets the bench confirm hit versus miss, the lane strobes and the minimum pulse widths independently of the design.

// File: rtl/edo_pkg.sv
package edo_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_RSET,
    S_RCD,
    S_COL,
    S_CAS,
    S_CP,
    S_PRE,
    S_CBR_CAS,
    S_CBR_RAS
  } edo_st_e;
endpackage

// File: rtl/edo_run_cnt.sv
module edo_run_cnt #(
  parameter int W        = 8,
  parameter bit RST_FULL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         lvl,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_d;

  always_comb begin
    if (!lvl)      cnt_d = '0;
    else if (&cnt) cnt_d = cnt;
    else           cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= {W{RST_FULL}};
    else        cnt <= cnt_d;
  end
endmodule

// File: rtl/edo_tmr.sv
module edo_tmr #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic         zero
);
  logic [W-1:0] tmr_q, tmr_d;

  assign zero = (tmr_q == '0);

  always_comb begin
    if (ld)         tmr_d = ld_val;
    else if (!zero) tmr_d = tmr_q - 1'b1;
    else            tmr_d = tmr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_q <= '0;
    else        tmr_q <= tmr_d;
  end
endmodule

// File: rtl/edo_fsm.sv
module edo_fsm import edo_pkg::*; #(
  parameter int T_RCD     = 3,
  parameter int T_CAS     = 4,
  parameter int T_CP      = 2,
  parameter int T_RP      = 8,
  parameter int T_RAS_MIN = 13,
  parameter int T_CSR     = 2,
  parameter int TW        = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_hit,
  input  logic          ref_req,
  input  logic          ras_ok,
  input  logic          rasp_due,
  input  logic          tmr_zero,
  output edo_st_e       st_q,
  output logic          row_open_q,
  output logic          req_ready,
  output logic          accept,
  output logic          tmr_ld,
  output logic [TW-1:0] tmr_val,
  output logic          cap_rd,
  output logic          ref_ack
);
  edo_st_e st_d;
  logic    row_d;
  logic    ack_d;
  logic    close_req;

  assign close_req = ref_req || rasp_due || (req_valid && !req_hit);
  assign accept    = req_valid && req_ready;

  always_comb begin
    st_d      = st_q;
    row_d     = row_open_q;
    tmr_ld    = 1'b0;
    tmr_val   = '0;
    cap_rd    = 1'b0;
    ack_d     = 1'b0;
    req_ready = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (row_open_q) begin
          req_ready = !ref_req && !rasp_due && req_hit;
          if (close_req && ras_ok) begin
            st_d    = S_PRE;
            row_d   = 1'b0;
            tmr_ld  = 1'b1;
            tmr_val = TW'(T_RP - 1);
          end else if (accept) begin
            st_d = S_COL;
          end
        end else begin
          req_ready = !ref_req;
          if (ref_req) begin
            st_d    = S_CBR_CAS;
            tmr_ld  = 1'b1;
            tmr_val = TW'(T_CSR - 1);
          end else if (req_valid) begin
            st_d = S_RSET;
          end
        end
      end
      S_RSET: begin
        st_d    = S_RCD;
        row_d   = 1'b1;
        tmr_ld  = 1'b1;
        tmr_val = TW'(T_RCD - 1);
      end
      S_RCD: if (tmr_zero) st_d = S_COL;
      S_COL: begin
        st_d    = S_CAS;
        tmr_ld  = 1'b1;
        tmr_val = TW'(T_CAS - 1);
      end
      S_CAS: if (tmr_zero) begin
        st_d    = S_CP;
        tmr_ld  = 1'b1;
        tmr_val = TW'(T_CP - 1);
        cap_rd  = 1'b1;
      end
      S_CP:  if (tmr_zero) st_d = S_IDLE;
      S_PRE: if (tmr_zero) st_d = S_IDLE;
      S_CBR_CAS: if (tmr_zero) begin
        st_d    = S_CBR_RAS;
        tmr_ld  = 1'b1;
        tmr_val = TW'(T_RAS_MIN - 1);
      end
      S_CBR_RAS: if (tmr_zero) begin
        st_d    = S_PRE;
        tmr_ld  = 1'b1;
        tmr_val = TW'(T_RP - 1);
        ack_d   = 1'b1;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      row_open_q <= 1'b0;
      ref_ack    <= 1'b0;
    end else begin
      st_q       <= st_d;
      row_open_q <= row_d;
      ref_ack    <= ack_d;
    end
  end

  // R9: the acknowledge is one cycle wide and arrives with the row strobe closing
  p_ack_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ref_ack |=> !ref_ack);
  // R3: a request is only taken in the idle state
  p_accept_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (st_q == S_COL || st_q == S_RSET));
endmodule

// File: rtl/edo_dram_ctrl.sv
module edo_dram_ctrl import edo_pkg::*; #(
  parameter int ROW_W      = 10,
  parameter int COL_W      = 10,
  parameter int DQ_W       = 16,
  parameter int T_RCD      = 3,
  parameter int T_CAS      = 4,
  parameter int T_CP       = 2,
  parameter int T_RP       = 8,
  parameter int T_RAS_MIN  = 13,
  parameter int T_CSR      = 2,
  parameter int T_RASP_MAX = 25000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic                   req_we,
  input  logic [DQ_W/8-1:0]      req_be,
  input  logic [DQ_W-1:0]        req_wdata,
  output logic                   rsp_valid,
  output logic [DQ_W-1:0]        rsp_rdata,
  input  logic                   ref_req,
  output logic                   ref_ack,
  output logic                   dram_ras_n,
  output logic [DQ_W/8-1:0]      dram_cas_n,
  output logic                   dram_we_n,
  output logic                   dram_oe_n,
  output logic [ROW_W-1:0]       dram_addr,
  output logic [DQ_W-1:0]        dram_dq_out,
  output logic                   dram_dq_oe,
  input  logic [DQ_W-1:0]        dram_dq_in
);
  localparam int NB       = DQ_W / 8;
  localparam int ADDR_W   = ROW_W + COL_W;
  localparam int CNT_W    = $clog2(T_RASP_MAX + 1);
  localparam int TW       = $clog2(T_RCD + T_CAS + T_CP + T_RP + T_RAS_MIN + T_CSR + 1);
  localparam int RASP_LIM = T_RASP_MAX - T_CAS - T_CP - 4;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  edo_st_e         st_q;
  logic            row_open_q, accept, tmr_ld, tmr_zero, cap_rd;
  logic [TW-1:0]   tmr_val;
  logic            req_hit, ras_ok, rasp_due, cas_any_lo;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic            we_q;
  logic [NB-1:0]   be_q;
  logic [DQ_W-1:0] wdata_q, rd_mask;
  logic [CNT_W-1:0] run_cnt [4];
  logic [3:0]      run_lvl;
  logic [CNT_W-1:0] ras_lo_cnt, ras_hi_cnt, cas_lo_cnt, cas_hi_cnt;

  // request latch
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      row_q   <= '0;
      col_q   <= '0;
      we_q    <= 1'b0;
      be_q    <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      row_q   <= req_addr[ADDR_W-1:COL_W];
      col_q   <= req_addr[COL_W-1:0];
      we_q    <= req_we;
      be_q    <= req_be;
      wdata_q <= req_wdata;
    end
  end

  assign req_hit  = (req_addr[ADDR_W-1:COL_W] == row_q);
  assign ras_ok   = (ras_lo_cnt >= CNT_W'(T_RAS_MIN - 1));
  assign rasp_due = (ras_lo_cnt >= CNT_W'(RASP_LIM));

  edo_fsm #(
    .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP), .T_RP(T_RP),
    .T_RAS_MIN(T_RAS_MIN), .T_CSR(T_CSR), .TW(TW)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n_s), .req_valid(req_valid), .req_hit(req_hit),
    .ref_req(ref_req), .ras_ok(ras_ok), .rasp_due(rasp_due), .tmr_zero(tmr_zero),
    .st_q(st_q), .row_open_q(row_open_q), .req_ready(req_ready), .accept(accept),
    .tmr_ld(tmr_ld), .tmr_val(tmr_val), .cap_rd(cap_rd), .ref_ack(ref_ack)
  );

  edo_tmr #(.W(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n_s), .ld(tmr_ld), .ld_val(tmr_val), .zero(tmr_zero)
  );

  // pin decode
  logic cbr, in_wr, in_rd;
  assign cbr   = (st_q == S_CBR_CAS) || (st_q == S_CBR_RAS);
  assign in_wr = we_q && ((st_q == S_COL) || (st_q == S_CAS));
  assign in_rd = !we_q && ((st_q == S_COL) || (st_q == S_CAS) || (st_q == S_CP));

  assign dram_ras_n  = !(row_open_q || (st_q == S_CBR_RAS));
  assign dram_we_n   = !in_wr;
  assign dram_dq_oe  = in_wr;
  assign dram_oe_n   = !in_rd;
  assign dram_addr   = ((st_q == S_RSET) || (st_q == S_RCD)) ? row_q : col_q;
  assign dram_dq_out = wdata_q;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign dram_cas_n[b]       = !(cbr || ((st_q == S_CAS) && be_q[b]));
    assign rd_mask[b*8 +: 8]   = be_q[b] ? dram_dq_in[b*8 +: 8] : 8'h00;
    // R5: a lane strobe falls in an access only for an enabled lane
    p_be_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
      ($fell(dram_cas_n[b]) && !dram_ras_n) |-> be_q[b]);
  end

  // read capture
  logic rd_cap;
  assign rd_cap = cap_rd && !we_q;
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_cap;
      if (rd_cap) rsp_rdata <= rd_mask;
    end
  end

  // strobe run-length counters
  assign cas_any_lo = !(&dram_cas_n);
  assign run_lvl    = {!cas_any_lo, cas_any_lo, dram_ras_n, !dram_ras_n};
  for (genvar i = 0; i < 4; i++) begin : g_run
    edo_run_cnt #(.W(CNT_W), .RST_FULL(i % 2 == 1)) u_run (
      .clk(clk), .rst_n(rst_n_s), .lvl(run_lvl[i]), .cnt(run_cnt[i])
    );
  end
  assign ras_lo_cnt = run_cnt[0];
  assign ras_hi_cnt = run_cnt[1];
  assign cas_lo_cnt = run_cnt[2];
  assign cas_hi_cnt = run_cnt[3];

  // R4: row strobe width and precharge
  p_ras_min_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(dram_ras_n) |-> ras_lo_cnt >= CNT_W'(T_RAS_MIN));
  p_rp_min_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    $fell(dram_ras_n) |-> ras_hi_cnt >= CNT_W'(T_RP));
  // R10: page open time bound
  p_rasp_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
    !dram_ras_n |-> ras_lo_cnt < CNT_W'(T_RASP_MAX));
  // R2: row address held while the row strobe settles
  p_row_hold_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!dram_ras_n && $past(!dram_ras_n) && ras_lo_cnt < CNT_W'(T_RCD)) |-> $stable(dram_addr));
  // R8: column strobe width and precharge
  p_cas_w_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(&dram_cas_n) |-> cas_lo_cnt >= CNT_W'(T_CAS));
  p_cp_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    $fell(&dram_cas_n) |-> cas_hi_cnt >= CNT_W'(T_CP));
  // R6: write enable leads the column strobe, bus driven, outputs off
  p_early_wr_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    ($fell(&dram_cas_n) && !dram_we_n) |-> ($past(!dram_we_n) && dram_dq_oe && dram_oe_n));
  // R9: column strobes lead the row strobe in a refresh
  p_csr_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    ($fell(dram_ras_n) && !(|dram_cas_n)) |-> cas_lo_cnt >= CNT_W'(T_CSR));
  // R7: single-cycle response taken while output enable was active
  p_rsp_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    rsp_valid |=> !rsp_valid);
  p_rsp_oe_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    rsp_valid |-> $past(!dram_oe_n));
endmodule

// File: tb/edo_dram_ctrl_tb.sv
`timescale 1ns/1ps
module edo_dram_ctrl_tb;
  localparam int T_RCD = 3, T_CAS = 4, T_CP = 2, T_RP = 8, T_RAS_MIN = 13;
  localparam int T_CSR = 2, T_RASP_MAX = 25000;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready, req_we, rsp_valid, ref_req, ref_ack;
  logic [19:0] req_addr;
  logic [1:0]  req_be, dram_cas_n;
  logic [15:0] req_wdata, rsp_rdata, dram_dq_out, dram_dq_in;
  logic dram_ras_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [9:0] dram_addr;

  always #2 clk = ~clk;

  edo_dram_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_we(req_we), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ref_req(ref_req), .ref_ack(ref_ack),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_oe_n(dram_oe_n), .dram_addr(dram_addr), .dram_dq_out(dram_dq_out),
    .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model, reacts on the falling clock edge
  logic [15:0] mem [256];
  logic [9:0]  row_lat;
  int ras_falls = 0, refreshes = 0, rsp_cnt = 0, early_viol = 0;
  int ras_lo_run = 0, ras_hi_run = 1000, cas_lo_run = 0, cas_hi_run = 1000;
  int min_lo = 1000000, min_hi = 1000000, min_cas = 1000000, min_cp = 1000000;
  int min_csr = 1000000, max_lo = 0;
  bit prev_ras = 1, prev_cas_lo = 0, prev_we = 1;
  bit lstr, ustr;

  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_valid) rsp_cnt++;
      if (!dram_ras_n) begin
        if (prev_ras) begin
          ras_falls++;
          if (ras_hi_run < min_hi) min_hi = ras_hi_run;
          row_lat = dram_addr;
          if (dram_cas_n == 2'b00) begin
            refreshes++;
            if (cas_lo_run < min_csr) min_csr = cas_lo_run;
          end
          ras_lo_run = 1;
        end else ras_lo_run++;
        if (ras_lo_run > max_lo) max_lo = ras_lo_run;
      end else begin
        if (!prev_ras && ras_lo_run < min_lo) min_lo = ras_lo_run;
        ras_hi_run = prev_ras ? ras_hi_run + 1 : 1;
      end
      if (dram_cas_n != 2'b11) begin
        if (!prev_cas_lo) begin
          if (!dram_ras_n) begin
            if (cas_hi_run < min_cp) min_cp = cas_hi_run;
            if (!dram_cas_n[0]) lstr = 1;
            if (!dram_cas_n[1]) ustr = 1;
            if (!dram_we_n) begin
              if (prev_we || !dram_dq_oe) early_viol++;
              if (!dram_cas_n[0]) mem[{row_lat[3:0], dram_addr[3:0]}][7:0]  = dram_dq_out[7:0];
              if (!dram_cas_n[1]) mem[{row_lat[3:0], dram_addr[3:0]}][15:8] = dram_dq_out[15:8];
            end else begin
              dram_dq_in = mem[{row_lat[3:0], dram_addr[3:0]}];
            end
          end
          cas_lo_run = 1;
        end else cas_lo_run++;
      end else begin
        if (prev_cas_lo && cas_lo_run < min_cas) min_cas = cas_lo_run;
        cas_hi_run = prev_cas_lo ? 1 : cas_hi_run + 1;
      end
      prev_ras    = dram_ras_n;
      prev_cas_lo = (dram_cas_n != 2'b11);
      prev_we     = dram_we_n;
    end
  end

  task automatic access(input logic we, input logic [1:0] be, input logic [19:0] a,
                        input logic [15:0] wd, input logic [15:0] exp, input logic hit);
    int f0, r0, n;
    f0 = ras_falls; r0 = rsp_cnt; lstr = 0; ustr = 0;
    @(negedge clk);
    req_valid = 1; req_we = we; req_be = be; req_addr = a; req_wdata = wd;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    if (!we) begin
      n = 0;
      do begin @(negedge clk); n++; end while (!rsp_valid && n < 80);
      chk(n == (hit ? T_CAS + 1 : T_RCD + T_CAS + 2), "R3 read latency", n,
          hit ? T_CAS + 1 : T_RCD + T_CAS + 2);
      chk(rsp_rdata == exp, "R7 read data", rsp_rdata, exp);
      @(negedge clk);
      chk(!rsp_valid, "R7 single pulse", rsp_valid, 0);
      repeat (T_CP) @(negedge clk);
    end else begin
      repeat (T_RCD + T_CAS + T_CP + 4) @(negedge clk);
      chk(rsp_cnt == r0, "R6 no response on write", rsp_cnt - r0, 0);
    end
    chk((ras_falls - f0) == (hit ? 0 : 1), hit ? "R3 page hit" : "R2 row open",
        ras_falls - f0, hit ? 0 : 1);
    chk({ustr, lstr} == be, "R5 lane strobes", {ustr, lstr}, be);
  endtask

  // vector: we, be, addr, wdata, expected read data, hit
  localparam logic [55:0] VEC [8] = '{
    {1'b1, 2'b11, 20'h01401, 16'hA1B2, 16'h0000, 1'b0},
    {1'b1, 2'b01, 20'h01402, 16'h00C3, 16'h0000, 1'b1},
    {1'b1, 2'b10, 20'h01402, 16'hD400, 16'h0000, 1'b1},
    {1'b0, 2'b11, 20'h01402, 16'h0000, 16'hD4C3, 1'b1},
    {1'b0, 2'b01, 20'h01401, 16'h0000, 16'h00B2, 1'b1},
    {1'b1, 2'b11, 20'h02403, 16'h5E6F, 16'h0000, 1'b0},
    {1'b0, 2'b10, 20'h02403, 16'h0000, 16'h5E00, 1'b1},
    {1'b0, 2'b11, 20'h01401, 16'h0000, 16'hA1B2, 1'b0}
  };

  always @(posedge clk) begin : watchdog
    int cyc;
    cyc++;
    if (cyc > 150000 && !done) begin
      chk(0, "watchdog", cyc, 150000);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int f0, rf0, n;
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    dram_dq_in = 16'h0000;
    rst_n = 0; req_valid = 0; req_we = 0; req_be = 0; req_addr = 0; req_wdata = 0; ref_req = 0;
    repeat (5) @(negedge clk);
    chk(dram_ras_n && dram_cas_n == 2'b11 && dram_we_n && dram_oe_n, "R1 strobes idle in reset",
        {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 5'h1F);
    chk(!dram_dq_oe && !rsp_valid, "R1 outputs quiet in reset", {dram_dq_oe, rsp_valid}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(req_ready, "R1 ready after reset", req_ready, 1);

    for (int v = 0; v < 8; v++)
      access(VEC[v][55], VEC[v][54:53], VEC[v][52:33], VEC[v][32:17], VEC[v][16:1], VEC[v][0]);

    // R9 refresh while a row is open
    rf0 = refreshes;
    @(negedge clk);
    ref_req = 1;
    #1;
    chk(!req_ready, "R9 no accept during refresh", req_ready, 0);
    n = 0;
    while (!ref_ack && n < 200) begin @(negedge clk); n++; end
    ref_req = 0;
    chk(ref_ack, "R9 refresh acknowledged", ref_ack, 1);
    chk(refreshes - rf0 == 1, "R9 one refresh cycle", refreshes - rf0, 1);
    chk(min_csr >= T_CSR, "R9 column lead before row strobe", min_csr, T_CSR);
    access(1'b0, 2'b11, 20'h01401, 16'h0000, 16'hA1B2, 1'b0);

    // R5 write with no lane enabled leaves memory alone
    access(1'b1, 2'b00, 20'h01401, 16'hFFFF, 16'h0000, 1'b1);
    access(1'b0, 2'b11, 20'h01401, 16'h0000, 16'hA1B2, 1'b1);

    // R10 idle open row closes by itself
    n = 0;
    while (!dram_ras_n && n < T_RASP_MAX + 100) begin @(negedge clk); n++; end
    chk(dram_ras_n, "R10 row closed when idle", dram_ras_n, 1);
    chk(max_lo < T_RASP_MAX, "R10 row open time bound", max_lo, T_RASP_MAX);
    f0 = ras_falls;
    access(1'b0, 2'b01, 20'h01401, 16'h0000, 16'h00B2, 1'b0);
    chk(ras_falls - f0 == 1, "R10 reopen after timeout", ras_falls - f0, 1);

    // timing minima observed at the pins
    chk(min_lo >= T_RAS_MIN, "R4 row strobe width", min_lo, T_RAS_MIN);
    chk(min_hi >= T_RP, "R4 row precharge", min_hi, T_RP);
    chk(min_cas >= T_CAS, "R8 column strobe width", min_cas, T_CAS);
    chk(min_cp >= T_CP, "R8 column precharge", min_cp, T_CP);
    chk(early_viol == 0, "R6 early write", early_viol, 0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule